// File: doc/BRIEF.md
# Latched-Operand Instruction Execute Unit

This block is the execute stage of a small multiply-accumulate compute cell that runs its memories with registered reads. Fetch and operand-read phases happen elsewhere. They hand this unit a decoded instruction (opcode, destination and source register indices, a signed immediate and a local address field) together with three values already captured from memory: a load word, a weight element and a stream element. The unit holds the architectural state: program counter, register file, accumulator, weight and stream local pointers, and the halted flag. On each accepted execute strobe it commits exactly one instruction in a single clock.

Instructions arrive as a valid/ready transfer. `ex_valid` offers an instruction. `ex_ready` is high whenever the unit is not halted. An instruction is accepted on a rising clock edge where both are high. Back-pressure is permanent once a halt has committed: `ex_ready` stays low until reset, and a strobe offered during that time is dropped, not held. Data memory appears only as a write port. That port is driven combinationally during the accepted cycle so that an external array captures it on the same edge. The value of register `ra` is brought out so that the read phase can form the load address.

Top module: `opx_execute`

## Requirements
- R1: After reset, the program counter, accumulator, both pointers and every register are zero, the unit is not halted and `ex_ready` is high.
- R2: Opcode 0 (multiply-accumulate on registers) adds the signed product of the low 8 bits of register ra and the low 8 bits of register rb, each sign-extended, to the 40-bit accumulator.
- R3: Opcode 1 (kernel multiply-accumulate) adds the signed product of `lat_weight` and `lat_stream` to the accumulator. In the same commit it advances both the weight pointer and the stream pointer by one, wrapping from 255 to 0.
- R4: Opcode 2 clears the accumulator. Opcode 3 writes the low 32 bits of the accumulator into register rd.
- R5: Opcode 4 writes the 16-bit immediate, sign-extended to 32 bits, into register rd. Opcode 5 writes `lat_load` into register rd.
- R6: Opcode 6 (store) raises `dm_we` during the accepted cycle only, with `dm_addr` set to the low 16 bits of register ra and `dm_wdata` set to register rb. No other opcode and no unaccepted cycle raises `dm_we`.
- R7: Opcode 7 loads the weight pointer from the address field and leaves the stream pointer unchanged. Opcode 8 loads the stream pointer and leaves the weight pointer unchanged.
- R8: Opcode 9 (branch) adds the sign-extended immediate to the program counter when register ra, read as signed, is less than or equal to zero. Otherwise the program counter advances by one.
- R9: Every opcode from 0 to 8 advances the program counter by one.
- R10: Opcode 10, and every unused code from 11 to 15, sets the halted flag, lowers `ex_ready` and changes no other state. While the unit is halted, strobes change nothing and raise no memory write.
- R11: State changes only on an edge where `ex_valid` and `ex_ready` are both high. An accepted instruction's results are visible right after that one edge.
- R12: `opa_value` shows the current value of register ra at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ex_valid | input | 1 | Instruction offered for execution |
| ex_ready | output | 1 | Unit can accept an instruction (not halted) |
| in_op | input | 4 | Opcode |
| in_rd | input | 4 | Destination register index |
| in_ra | input | 4 | First source register index |
| in_rb | input | 4 | Second source register index |
| in_imm | input | 16 | Signed immediate |
| in_addr | input | 8 | Local address field for pointer loads |
| lat_load | input | 32 | Latched data-memory word |
| lat_weight | input | 8 | Latched weight element |
| lat_stream | input | 8 | Latched stream element |
| opa_value | output | 32 | Current value of register ra |
| dm_we | output | 1 | Data-memory write enable |
| dm_addr | output | 16 | Data-memory write address |
| dm_wdata | output | 32 | Data-memory write data |
| pc_q | output | 16 | Program counter |
| acc_q | output | 40 | Accumulator |
| wptr_q | output | 8 | Weight pointer |
| sptr_q | output | 8 | Stream pointer |
| halted_q | output | 1 | Halted flag |

## Verification
The memory write port and `opa_value` depend only on the offered instruction and the current state, so their results are due in the cycle the strobe is offered. The bench samples them one nanosecond after it drives the fields, well before the accepting edge. Program counter, accumulator, pointers and halted flag pass through one register, so the bench samples them one nanosecond after the accepting edge, with the strobe already withdrawn. Register-file contents have no direct port. The bench reads them back through a later store's write data or through `opa_value`, one instruction after the write.

// File: rtl/opx_pkg.sv
package opx_pkg;

  typedef enum logic [3:0] {
    OP_MAC    = 4'd0,
    OP_KMAC   = 4'd1,
    OP_CLRACC = 4'd2,
    OP_MOVACC = 4'd3,
    OP_LI     = 4'd4,
    OP_LD     = 4'd5,
    OP_ST     = 4'd6,
    OP_SETW   = 4'd7,
    OP_SETS   = 4'd8,
    OP_BLZ    = 4'd9,
    OP_HALT   = 4'd10
  } opx_op_e;

  typedef enum logic [1:0] {
    WB_ACC  = 2'd0,
    WB_IMM  = 2'd1,
    WB_LOAD = 2'd2
  } opx_wb_e;

  typedef struct packed {
    logic    mac_reg;
    logic    mac_kern;
    logic    clr_acc;
    logic    wr_reg;
    opx_wb_e wb_sel;
    logic    store;
    logic    set_w;
    logic    set_s;
    logic    branch;
    logic    halt;
  } opx_ctl_t;

endpackage

// File: rtl/opx_decode.sv
module opx_decode
  import opx_pkg::*;
(
  input  logic [3:0] op,
  output opx_ctl_t   ctl
);
  always_comb begin
    ctl = '0;
    ctl.wb_sel = WB_ACC;
    case (op)
      OP_MAC:    ctl.mac_reg  = 1'b1;
      OP_KMAC:   ctl.mac_kern = 1'b1;
      OP_CLRACC: ctl.clr_acc  = 1'b1;
      OP_MOVACC: begin
        ctl.wr_reg = 1'b1;
        ctl.wb_sel = WB_ACC;
      end
      OP_LI: begin
        ctl.wr_reg = 1'b1;
        ctl.wb_sel = WB_IMM;
      end
      OP_LD: begin
        ctl.wr_reg = 1'b1;
        ctl.wb_sel = WB_LOAD;
      end
      OP_ST:   ctl.store  = 1'b1;
      OP_SETW: ctl.set_w  = 1'b1;
      OP_SETS: ctl.set_s  = 1'b1;
      OP_BLZ:  ctl.branch = 1'b1;
      default: ctl.halt   = 1'b1;  // halt and every unused code
    endcase
  end
endmodule

// File: rtl/opx_regfile.sv
module opx_regfile #(
  parameter int NREGS = 16,
  parameter int XLEN  = 32,
  localparam int RIDX_W = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [RIDX_W-1:0] widx,
  input  logic [XLEN-1:0]   wdata,
  input  logic [RIDX_W-1:0] ridx_a,
  input  logic [RIDX_W-1:0] ridx_b,
  output logic [XLEN-1:0]   rdata_a,
  output logic [XLEN-1:0]   rdata_b
);
  logic [XLEN-1:0] regs_q [NREGS];
  logic [NREGS-1:0] wen;

  for (genvar g = 0; g < NREGS; g++) begin : g_wen
    assign wen[g] = we && (widx == RIDX_W'(g));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NREGS; i++) begin
      if (!rst_n)      regs_q[i] <= '0;
      else if (wen[i]) regs_q[i] <= wdata;
    end
  end

  assign rdata_a = regs_q[ridx_a];
  assign rdata_b = regs_q[ridx_b];
endmodule

// File: rtl/opx_mac.sv
module opx_mac #(
  parameter int ELEM_W = 8,
  parameter int ACC_W  = 40,
  localparam int PROD_W = 2 * ELEM_W
) (
  input  logic [ELEM_W-1:0] x,
  input  logic [ELEM_W-1:0] y,
  input  logic [ACC_W-1:0]  acc_in,
  output logic [ACC_W-1:0]  acc_out
);
  logic signed [PROD_W-1:0] prod;
  assign prod    = $signed(x) * $signed(y);
  assign acc_out = acc_in + ACC_W'(prod);
endmodule

// File: rtl/opx_execute.sv
module opx_execute
  import opx_pkg::*;
#(
  parameter int NREGS  = 16,
  parameter int XLEN   = 32,
  parameter int ELEM_W = 8,
  parameter int ACC_W  = 40,
  parameter int PC_W   = 16,
  parameter int IMM_W  = 16,
  parameter int PTR_W  = 8,
  parameter int DM_AW  = 16,
  localparam int RIDX_W = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ex_valid,
  output logic              ex_ready,
  input  logic [3:0]        in_op,
  input  logic [RIDX_W-1:0] in_rd,
  input  logic [RIDX_W-1:0] in_ra,
  input  logic [RIDX_W-1:0] in_rb,
  input  logic [IMM_W-1:0]  in_imm,
  input  logic [PTR_W-1:0]  in_addr,
  input  logic [XLEN-1:0]   lat_load,
  input  logic [ELEM_W-1:0] lat_weight,
  input  logic [ELEM_W-1:0] lat_stream,
  output logic [XLEN-1:0]   opa_value,
  output logic              dm_we,
  output logic [DM_AW-1:0]  dm_addr,
  output logic [XLEN-1:0]   dm_wdata,
  output logic [PC_W-1:0]   pc_q,
  output logic [ACC_W-1:0]  acc_q,
  output logic [PTR_W-1:0]  wptr_q,
  output logic [PTR_W-1:0]  sptr_q,
  output logic              halted_q
);
  opx_ctl_t        ctl;
  logic            accept;
  logic [XLEN-1:0] ra_val, rb_val;
  logic [XLEN-1:0] wb_data;
  logic [ELEM_W-1:0] mac_x, mac_y;
  logic [ACC_W-1:0]  mac_sum;
  logic [PC_W-1:0]   pc_next;
  logic              ra_le_zero;

  assign ex_ready = !halted_q;
  assign accept   = ex_valid && ex_ready;

  opx_decode u_decode (
    .op  (in_op),
    .ctl (ctl)
  );

  opx_regfile #(.NREGS(NREGS), .XLEN(XLEN)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (accept && ctl.wr_reg),
    .widx    (in_rd),
    .wdata   (wb_data),
    .ridx_a  (in_ra),
    .ridx_b  (in_rb),
    .rdata_a (ra_val),
    .rdata_b (rb_val)
  );

  // One multiplier serves both MAC forms; operands chosen by opcode.
  assign mac_x = ctl.mac_kern ? lat_weight : ra_val[ELEM_W-1:0];
  assign mac_y = ctl.mac_kern ? lat_stream : rb_val[ELEM_W-1:0];

  opx_mac #(.ELEM_W(ELEM_W), .ACC_W(ACC_W)) u_mac (
    .x       (mac_x),
    .y       (mac_y),
    .acc_in  (acc_q),
    .acc_out (mac_sum)
  );

  always_comb begin
    case (ctl.wb_sel)
      WB_IMM:  wb_data = XLEN'($signed(in_imm));
      WB_LOAD: wb_data = lat_load;
      default: wb_data = acc_q[XLEN-1:0];
    endcase
  end

  assign ra_le_zero = ra_val[XLEN-1] || (ra_val == '0);
  assign pc_next    = (ctl.branch && ra_le_zero) ? pc_q + PC_W'($signed(in_imm))
                                                 : pc_q + PC_W'(1);

  assign opa_value = ra_val;
  assign dm_we     = accept && ctl.store;
  assign dm_addr   = ra_val[DM_AW-1:0];
  assign dm_wdata  = rb_val;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q     <= '0;
      acc_q    <= '0;
      wptr_q   <= '0;
      sptr_q   <= '0;
      halted_q <= 1'b0;
    end else if (accept) begin
      if (ctl.halt) begin
        halted_q <= 1'b1;
      end else begin
        pc_q <= pc_next;
        if (ctl.mac_reg || ctl.mac_kern) acc_q <= mac_sum;
        else if (ctl.clr_acc)            acc_q <= '0;
        if (ctl.set_w)         wptr_q <= in_addr;
        else if (ctl.mac_kern) wptr_q <= wptr_q + PTR_W'(1);
        if (ctl.set_s)         sptr_q <= in_addr;
        else if (ctl.mac_kern) sptr_q <= sptr_q + PTR_W'(1);
      end
    end
  end

  // ---------------- assertions ----------------
  assert_halt_freezes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    halted_q |=> (halted_q && $stable(pc_q) && $stable(acc_q) && $stable(wptr_q)));

  assert_store_only_accepted_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dm_we |-> (ex_valid && !halted_q && in_op == 4'd6));

  assert_idle_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_valid |=> ($stable(pc_q) && $stable(acc_q) && $stable(wptr_q) && $stable(sptr_q)));

  assert_kernel_ptr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && !halted_q && in_op == 4'd1) |=>
      (wptr_q == $past(wptr_q) + PTR_W'(1) && sptr_q == $past(sptr_q) + PTR_W'(1)));

  assert_pc_fallthrough_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && !halted_q && in_op <= 4'd8) |=> (pc_q == $past(pc_q) + PC_W'(1)));
endmodule

// File: tb/test_opx_execute.sv
module test_opx_execute;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ex_valid = 1'b0;
  logic        ex_ready;
  logic [3:0]  in_op = '0, in_rd = '0, in_ra = '0, in_rb = '0;
  logic [15:0] in_imm = '0;
  logic [7:0]  in_addr = '0;
  logic [31:0] lat_load = '0;
  logic [7:0]  lat_weight = '0, lat_stream = '0;
  logic [31:0] opa_value, dm_wdata;
  logic        dm_we, halted_q;
  logic [15:0] dm_addr, pc_q;
  logic [39:0] acc_q;
  logic [7:0]  wptr_q, sptr_q;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;  // 125 MHz

  opx_execute i_opx_execute (
    .clk(clk), .rst_n(rst_n), .ex_valid(ex_valid), .ex_ready(ex_ready),
    .in_op(in_op), .in_rd(in_rd), .in_ra(in_ra), .in_rb(in_rb),
    .in_imm(in_imm), .in_addr(in_addr), .lat_load(lat_load),
    .lat_weight(lat_weight), .lat_stream(lat_stream), .opa_value(opa_value),
    .dm_we(dm_we), .dm_addr(dm_addr), .dm_wdata(dm_wdata), .pc_q(pc_q),
    .acc_q(acc_q), .wptr_q(wptr_q), .sptr_q(sptr_q), .halted_q(halted_q)
  );

  typedef struct packed {
    logic [3:0]  op, rd, ra, rb;
    logic [15:0] imm;
    logic [7:0]  addr;
    logic [31:0] ldw;
    logic [7:0]  wv, sv;
    logic [15:0] e_pc;
    logic [39:0] e_acc;
    logic [7:0]  e_w, e_s;
    logic        e_we;
    logic [15:0] e_da;
    logic [31:0] e_dd, e_opa;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{4'd4,4'd1,4'd0,4'd0,16'd5,   8'd0,  32'h0,       8'h00,8'h00, 16'd1, 40'h0,          8'd0,  8'd0,1'b0,16'h0,   32'h0,       32'h0},
    '{4'd4,4'd2,4'd0,4'd0,16'hFFFD,8'd0,  32'h0,       8'h00,8'h00, 16'd2, 40'h0,          8'd0,  8'd0,1'b0,16'h0,   32'h0,       32'h0},
    '{4'd0,4'd0,4'd1,4'd2,16'd0,   8'd0,  32'h0,       8'h00,8'h00, 16'd3, 40'hFFFFFFFFF1, 8'd0,  8'd0,1'b0,16'h0,   32'h0,       32'h5},
    '{4'd6,4'd0,4'd1,4'd2,16'd0,   8'd0,  32'h0,       8'h00,8'h00, 16'd4, 40'hFFFFFFFFF1, 8'd0,  8'd0,1'b1,16'h5,   32'hFFFFFFFD,32'h5},
    '{4'd7,4'd0,4'd0,4'd0,16'd0,   8'd254,32'h0,       8'h00,8'h00, 16'd5, 40'hFFFFFFFFF1, 8'd254,8'd0,1'b0,16'h0,   32'h0,       32'h0},
    '{4'd8,4'd0,4'd0,4'd0,16'd0,   8'd7,  32'h0,       8'h00,8'h00, 16'd6, 40'hFFFFFFFFF1, 8'd254,8'd7,1'b0,16'h0,   32'h0,       32'h0},
    '{4'd1,4'd0,4'd0,4'd0,16'd0,   8'd0,  32'h0,       8'h0A,8'hFE, 16'd7, 40'hFFFFFFFFDD, 8'd255,8'd8,1'b0,16'h0,   32'h0,       32'h0},
    '{4'd1,4'd0,4'd0,4'd0,16'd0,   8'd0,  32'h0,       8'h80,8'h80, 16'd8, 40'h3FDD,       8'd0,  8'd9,1'b0,16'h0,   32'h0,       32'h0},
    '{4'd3,4'd3,4'd0,4'd0,16'd0,   8'd0,  32'h0,       8'h00,8'h00, 16'd9, 40'h3FDD,       8'd0,  8'd9,1'b0,16'h0,   32'h0,       32'h0},
    '{4'd6,4'd0,4'd1,4'd3,16'd0,   8'd0,  32'h0,       8'h00,8'h00, 16'd10,40'h3FDD,       8'd0,  8'd9,1'b1,16'h5,   32'h3FDD,    32'h5},
    '{4'd5,4'd4,4'd1,4'd0,16'd0,   8'd0,  32'hCAFEF00D,8'h00,8'h00, 16'd11,40'h3FDD,       8'd0,  8'd9,1'b0,16'h0,   32'h0,       32'h5},
    '{4'd6,4'd0,4'd2,4'd4,16'd0,   8'd0,  32'h0,       8'h00,8'h00, 16'd12,40'h3FDD,       8'd0,  8'd9,1'b1,16'hFFFD,32'hCAFEF00D,32'hFFFFFFFD},
    '{4'd9,4'd0,4'd1,4'd0,16'd10,  8'd0,  32'h0,       8'h00,8'h00, 16'd13,40'h3FDD,       8'd0,  8'd9,1'b0,16'h0,   32'h0,       32'h5},
    '{4'd9,4'd0,4'd2,4'd0,16'hFFFB,8'd0,  32'h0,       8'h00,8'h00, 16'd8, 40'h3FDD,       8'd0,  8'd9,1'b0,16'h0,   32'h0,       32'hFFFFFFFD},
    '{4'd4,4'd5,4'd0,4'd0,16'd0,   8'd0,  32'h0,       8'h00,8'h00, 16'd9, 40'h3FDD,       8'd0,  8'd9,1'b0,16'h0,   32'h0,       32'h0},
    '{4'd9,4'd0,4'd5,4'd0,16'd20,  8'd0,  32'h0,       8'h00,8'h00, 16'd29,40'h3FDD,       8'd0,  8'd9,1'b0,16'h0,   32'h0,       32'h0},
    '{4'd2,4'd0,4'd0,4'd0,16'd0,   8'd0,  32'h0,       8'h00,8'h00, 16'd30,40'h0,          8'd0,  8'd9,1'b0,16'h0,   32'h0,       32'h0},
    '{4'd0,4'd0,4'd4,4'd2,16'd0,   8'd0,  32'h0,       8'h00,8'h00, 16'd31,40'hFFFFFFFFD9, 8'd0,  8'd9,1'b0,16'h0,   32'h0,       32'hCAFEF00D},
    '{4'd3,4'd6,4'd0,4'd0,16'd0,   8'd0,  32'h0,       8'h00,8'h00, 16'd32,40'hFFFFFFFFD9, 8'd0,  8'd9,1'b0,16'h0,   32'h0,       32'h0},
    '{4'd6,4'd0,4'd5,4'd6,16'd0,   8'd0,  32'h0,       8'h00,8'h00, 16'd33,40'hFFFFFFFFD9, 8'd0,  8'd9,1'b1,16'h0,   32'hFFFFFFD9,32'h0}
  };

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'd0:       return "R2";
      4'd1:       return "R3";
      4'd2, 4'd3: return "R4";
      4'd4, 4'd5: return "R5";
      4'd6:       return "R6";
      4'd7, 4'd8: return "R7";
      4'd9:       return "R8";
      default:    return "R10";
    endcase
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] op, input logic [3:0] rd, input logic [3:0] ra,
                       input logic [3:0] rb, input logic [15:0] imm, input logic [7:0] addr);
    in_op = op; in_rd = rd; in_ra = ra; in_rb = rb; in_imm = imm; in_addr = addr;
  endtask

  // Offer one instruction; comb results due in this cycle, state after one edge.
  task automatic step_vec(input vec_t v);
    drive(v.op, v.rd, v.ra, v.rb, v.imm, v.addr);
    lat_load = v.ldw; lat_weight = v.wv; lat_stream = v.sv;
    ex_valid = 1'b1;
    #1;
    chk("R6",  "dm_we",    64'(dm_we), 64'(v.e_we));
    if (v.e_we) begin
      chk("R6", "dm_addr",  64'(dm_addr),  64'(v.e_da));
      chk("R6", "dm_wdata", 64'(dm_wdata), 64'(v.e_dd));
    end
    chk("R12", "opa_value", 64'(opa_value), 64'(v.e_opa));
    @(posedge clk); #1;
    ex_valid = 1'b0;
    chk((v.op == 4'd9) ? "R8" : "R9", "pc", 64'(pc_q), 64'(v.e_pc));
    chk(tag_of(v.op), "acc",  64'(acc_q),  64'(v.e_acc));
    chk(tag_of(v.op), "wptr", 64'(wptr_q), 64'(v.e_w));
    chk(tag_of(v.op), "sptr", 64'(sptr_q), 64'(v.e_s));
  endtask

  task automatic offer(input logic [3:0] op, input logic [3:0] ra, input logic [3:0] rb);
    drive(op, 4'd0, ra, rb, 16'd0, 8'd0);
    ex_valid = 1'b1;
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset state
    chk("R1", "pc",     64'(pc_q),     64'd0);
    chk("R1", "acc",    64'(acc_q),    64'd0);
    chk("R1", "wptr",   64'(wptr_q),   64'd0);
    chk("R1", "sptr",   64'(sptr_q),   64'd0);
    chk("R1", "halted", 64'(halted_q), 64'd0);
    chk("R1", "ready",  64'(ex_ready), 64'd1);

    for (int i = 0; i < NV; i++) step_vec(VECS[i]);

    // R11: store fields present but no strobe -> no write, no state change
    drive(4'd6, 4'd0, 4'd1, 4'd2, 16'd0, 8'd0);
    ex_valid = 1'b0;
    #1 chk("R11", "dm_we idle", 64'(dm_we), 64'd0);
    @(posedge clk); #1;
    chk("R11", "pc idle",  64'(pc_q),  64'd33);
    chk("R11", "acc idle", 64'(acc_q), 64'hFFFFFFFFD9);

    // R10: halt
    offer(4'd10, 4'd0, 4'd0);
    #1 chk("R10", "dm_we on halt", 64'(dm_we), 64'd0);
    @(posedge clk); #1 ex_valid = 1'b0;
    chk("R10", "halted", 64'(halted_q), 64'd1);
    chk("R10", "ready",  64'(ex_ready), 64'd0);
    chk("R10", "pc held", 64'(pc_q), 64'd33);
    chk("R10", "acc held", 64'(acc_q), 64'hFFFFFFFFD9);

    // R10: strobes while halted are dropped
    offer(4'd6, 4'd1, 4'd2);
    #1 chk("R10", "dm_we while halted", 64'(dm_we), 64'd0);
    @(posedge clk); #1;
    offer(4'd2, 4'd0, 4'd0);
    @(posedge clk); #1 ex_valid = 1'b0;
    chk("R10", "pc after halted strobes",  64'(pc_q),  64'd33);
    chk("R10", "acc after halted strobes", 64'(acc_q), 64'hFFFFFFFFD9);

    // R1: reset mid-run clears registers as well as state
    rst_n = 1'b0;
    @(posedge clk); #1 rst_n = 1'b1;
    chk("R1", "halted after reset", 64'(halted_q), 64'd0);
    chk("R1", "pc after reset",     64'(pc_q),     64'd0);
    offer(4'd6, 4'd1, 4'd3);
    #1 chk("R1", "r1 cleared", 64'(dm_addr), 64'd0);
    chk("R1", "r3 cleared", 64'(dm_wdata), 64'd0);
    @(posedge clk); #1 ex_valid = 1'b0;
    chk("R9", "pc after store", 64'(pc_q), 64'd1);

    // R10: unused opcode behaves as halt
    offer(4'd13, 4'd0, 4'd0);
    @(posedge clk); #1 ex_valid = 1'b0;
    chk("R10", "unused op halts", 64'(halted_q), 64'd1);
    chk("R10", "unused op pc",    64'(pc_q),     64'd1);
    chk("R10", "unused op ready", 64'(ex_ready), 64'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule